// File: doc/BRIEF.md
# Two-Priority Process Scheduler

This block decides which software process a processor core should run. Processes are named by a small integer identifier. A process that becomes runnable is offered on a valid/ready request stream together with its priority. The core reports through plain control pins when the running process stops: it blocks waiting for an event, or it terminates. A periodic timeslice pulse also arrives on a plain pin. The scheduler answers with the identifier and priority of the process that should be executing, plus a valid flag.

Runnable processes that are not executing wait in one of two first-in first-out queues, one per priority. Each queue is held as a front register and a back register. The chain between them runs through a shared link table, indexed by process identifier, in which each waiting process holds the identifier of the process queued after it. The all-ones identifier is reserved as the null marker for an empty queue.

High-priority work preempts low-priority work at once. The preempted low-priority process is kept in a single saved slot and resumes before any queued low-priority process once no high-priority work remains. Only low-priority processes are timesliced. High-priority processes run until they block. Back-pressure rule: the request stream is accepted only in cycles where neither the block pin nor the tick pin is high. Each cycle performs one operation, with block ranked above tick and tick above a new request. The requester must hold `rdy_valid`, `rdy_id` and `rdy_hi` steady until it sees `rdy_ready`. It must also never offer an identifier that is already running, saved or queued.

Top module: `proc_sched`

## Requirements
- R1: After reset no process is executing (`run_valid` = 0), both queues are empty, and `rdy_ready` is 1 while `blk` and `tick` are low.
- R2: A request accepted while no process is executing makes that process the executing one in the next cycle, with `run_hi` equal to the requested priority (1 = high, 0 = low).
- R3: A high-priority request accepted while a low-priority process executes makes the requested process execute in the next cycle. The displaced low-priority process is saved in the single interrupted slot.
- R4: Any other accepted request is appended to the back of the queue of its own priority. Processes leave each queue in the order they entered it.
- R5: When `blk` is high while a process executes, the next process is chosen in this order: the front of the high queue, then the saved interrupted process, then the front of the low queue. If none of these exists, nothing executes.
- R6: A `tick` while a low-priority process executes and the low queue is non-empty moves the executing process to the back of the low queue. The front of the low queue starts executing in the next cycle.
- R7: A `tick` while a high-priority process executes, or while the low queue is empty, leaves the executing process and both queues unchanged.
- R8: `rdy_ready` is low in any cycle where `blk` or `tick` is high. A block arriving together with a request is processed first, and the request is left pending.
- R9: `run_valid` is 0 exactly when no process executes, both queues are empty and no process is saved as interrupted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rdy_valid | input | 1 | A process is offered as runnable |
| rdy_ready | output | 1 | The offered process is accepted this cycle |
| rdy_id | input | ID_W | Identifier of the offered process |
| rdy_hi | input | 1 | Priority of the offered process, 1 = high |
| blk | input | 1 | The executing process blocks or terminates |
| tick | input | 1 | Timeslice boundary pulse |
| run_valid | output | 1 | A process is selected to execute |
| run_id | output | ID_W | Identifier of the selected process |
| run_hi | output | 1 | Priority of the selected process |

## Verification
A corrupted front, back or link entry does not show up at once. It appears at the next dequeue from the damaged queue: a block or tick then puts a wrong, repeated or lost identifier on `run_id` one cycle after the pin is raised. The bench therefore compares the executing process every cycle against a queue model over long random runs. In those runs each queue fills, drains and wraps many times, so a damaged chain is reached within a few dequeues. A lost interrupted slot shows as a wrong low-priority process on the first block after high-priority work ends. A wrong idle decision shows directly on `run_valid`.

// File: rtl/sched_pkg.sv
package sched_pkg;
  // one operation is performed per cycle, ranked block > tick > request
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READY = 2'd1,
    OP_BLOCK = 2'd2,
    OP_TICK  = 2'd3
  } sched_op_e;

  localparam int unsigned PRIO_LO = 0;
  localparam int unsigned PRIO_HI = 1;
  localparam int unsigned NUM_PRIO = 2;
endpackage

// File: rtl/sched_link_tbl.sv
module sched_link_tbl #(
  parameter int unsigned ID_W = 4
) (
  input  logic            clk,
  input  logic            wr_en,
  input  logic [ID_W-1:0] wr_addr,
  input  logic [ID_W-1:0] wr_data,
  input  logic [ID_W-1:0] rd_addr_a,
  output logic [ID_W-1:0] rd_data_a,
  input  logic [ID_W-1:0] rd_addr_b,
  output logic [ID_W-1:0] rd_data_b
);
  localparam int unsigned DEPTH = 1 << ID_W;

  logic [ID_W-1:0] link_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) link_mem[wr_addr] <= wr_data;
  end

  assign rd_data_a = link_mem[rd_addr_a];
  assign rd_data_b = link_mem[rd_addr_b];
endmodule

// File: rtl/sched_linkq.sv
module sched_linkq #(
  parameter int unsigned ID_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  input  logic [ID_W-1:0] push_id,
  input  logic [ID_W-1:0] link_front,
  output logic [ID_W-1:0] front,
  output logic            empty,
  output logic            wr_en,
  output logic [ID_W-1:0] wr_addr,
  output logic [ID_W-1:0] wr_data
);
  localparam logic [ID_W-1:0] NULL_ID = '1;

  logic [ID_W-1:0] front_q, back_q, front_d, back_d;
  logic            single;

  assign empty  = (front_q == NULL_ID);
  assign single = (front_q == back_q);
  assign front  = front_q;

  always_comb begin
    front_d = front_q;
    back_d  = back_q;
    wr_en   = 1'b0;
    wr_addr = back_q;
    wr_data = push_id;
    if (push && pop) begin
      // rotate: old front leaves, new id joins the back
      if (single) begin
        front_d = push_id;
        back_d  = push_id;
      end else begin
        front_d = link_front;
        back_d  = push_id;
        wr_en   = 1'b1;
      end
    end else if (push) begin
      if (empty) begin
        front_d = push_id;
        back_d  = push_id;
      end else begin
        wr_en   = 1'b1;
        back_d  = push_id;
      end
    end else if (pop) begin
      if (single) begin
        front_d = NULL_ID;
        back_d  = NULL_ID;
      end else begin
        front_d = link_front;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      front_q <= NULL_ID;
      back_q  <= NULL_ID;
    end else begin
      front_q <= front_d;
      back_q  <= back_d;
    end
  end
endmodule

// File: rtl/proc_sched.sv
module proc_sched #(
  parameter int unsigned NPROC = 15,
  parameter int unsigned ID_W  = $clog2(NPROC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rdy_valid,
  output logic            rdy_ready,
  input  logic [ID_W-1:0] rdy_id,
  input  logic            rdy_hi,
  input  logic            blk,
  input  logic            tick,
  output logic            run_valid,
  output logic [ID_W-1:0] run_id,
  output logic            run_hi
);
  import sched_pkg::*;

  logic [NUM_PRIO-1:0] q_push, q_pop, q_empty, q_wr_en;
  logic [ID_W-1:0]     q_front [NUM_PRIO];
  logic [ID_W-1:0]     q_link  [NUM_PRIO];
  logic [ID_W-1:0]     q_wr_addr [NUM_PRIO];
  logic [ID_W-1:0]     q_wr_data [NUM_PRIO];
  logic [ID_W-1:0]     push_id;

  logic            cur_v_q, cur_v_d, cur_hi_q, cur_hi_d;
  logic [ID_W-1:0] cur_id_q, cur_id_d;
  logic            int_v_q, int_v_d;
  logic [ID_W-1:0] int_id_q, int_id_d;
  logic            hi_empty, lo_empty;
  sched_op_e       op;

  genvar g;
  generate
    for (g = 0; g < NUM_PRIO; g++) begin : g_queue
      sched_linkq #(.ID_W(ID_W)) u_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push[g]),
        .pop       (q_pop[g]),
        .push_id   (push_id),
        .link_front(q_link[g]),
        .front     (q_front[g]),
        .empty     (q_empty[g]),
        .wr_en     (q_wr_en[g]),
        .wr_addr   (q_wr_addr[g]),
        .wr_data   (q_wr_data[g])
      );
    end
  endgenerate

  // only one queue writes per cycle, since one operation runs per cycle
  logic            tbl_wr_en;
  logic [ID_W-1:0] tbl_wr_addr, tbl_wr_data;
  assign tbl_wr_en   = |q_wr_en;
  assign tbl_wr_addr = q_wr_en[PRIO_HI] ? q_wr_addr[PRIO_HI] : q_wr_addr[PRIO_LO];
  assign tbl_wr_data = q_wr_en[PRIO_HI] ? q_wr_data[PRIO_HI] : q_wr_data[PRIO_LO];

  sched_link_tbl #(.ID_W(ID_W)) u_tbl (
    .clk      (clk),
    .wr_en    (tbl_wr_en),
    .wr_addr  (tbl_wr_addr),
    .wr_data  (tbl_wr_data),
    .rd_addr_a(q_front[PRIO_LO]),
    .rd_data_a(q_link[PRIO_LO]),
    .rd_addr_b(q_front[PRIO_HI]),
    .rd_data_b(q_link[PRIO_HI])
  );

  assign hi_empty  = q_empty[PRIO_HI];
  assign lo_empty  = q_empty[PRIO_LO];
  assign rdy_ready = !blk && !tick;

  always_comb begin
    if (blk)            op = OP_BLOCK;
    else if (tick)      op = OP_TICK;
    else if (rdy_valid) op = OP_READY;
    else                op = OP_NONE;
  end

  always_comb begin
    q_push   = '0;
    q_pop    = '0;
    push_id  = rdy_id;
    cur_v_d  = cur_v_q;
    cur_hi_d = cur_hi_q;
    cur_id_d = cur_id_q;
    int_v_d  = int_v_q;
    int_id_d = int_id_q;
    unique case (op)
      OP_BLOCK: begin
        if (cur_v_q) begin
          if (!q_empty[PRIO_HI]) begin
            q_pop[PRIO_HI] = 1'b1;
            cur_id_d = q_front[PRIO_HI];
            cur_hi_d = 1'b1;
          end else if (int_v_q) begin
            cur_id_d = int_id_q;
            cur_hi_d = 1'b0;
            int_v_d  = 1'b0;
          end else if (!q_empty[PRIO_LO]) begin
            q_pop[PRIO_LO] = 1'b1;
            cur_id_d = q_front[PRIO_LO];
            cur_hi_d = 1'b0;
          end else begin
            cur_v_d = 1'b0;
          end
        end
      end
      OP_TICK: begin
        if (cur_v_q && !cur_hi_q && !q_empty[PRIO_LO]) begin
          q_push[PRIO_LO] = 1'b1;
          q_pop[PRIO_LO]  = 1'b1;
          push_id  = cur_id_q;
          cur_id_d = q_front[PRIO_LO];
        end
      end
      OP_READY: begin
        if (!cur_v_q) begin
          cur_v_d  = 1'b1;
          cur_id_d = rdy_id;
          cur_hi_d = rdy_hi;
        end else if (rdy_hi && !cur_hi_q) begin
          int_v_d  = 1'b1;
          int_id_d = cur_id_q;
          cur_id_d = rdy_id;
          cur_hi_d = 1'b1;
        end else begin
          q_push[rdy_hi] = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_v_q  <= 1'b0;
      cur_hi_q <= 1'b0;
      cur_id_q <= '0;
      int_v_q  <= 1'b0;
      int_id_q <= '0;
    end else begin
      cur_v_q  <= cur_v_d;
      cur_hi_q <= cur_hi_d;
      cur_id_q <= cur_id_d;
      int_v_q  <= int_v_d;
      int_id_q <= int_id_d;
    end
  end

  assign run_valid = cur_v_q;
  assign run_id    = cur_id_q;
  assign run_hi    = cur_hi_q;
endmodule

// File: rtl/sched_check.sv
module sched_check #(
  parameter int unsigned ID_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rdy_valid,
  input logic            rdy_ready,
  input logic [ID_W-1:0] rdy_id,
  input logic            rdy_hi,
  input logic            blk,
  input logic            tick,
  input logic            run_valid,
  input logic [ID_W-1:0] run_id,
  input logic            run_hi,
  input logic            hi_empty,
  input logic            lo_empty,
  input logic            int_valid
);
  AST_PREEMPT_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_valid && rdy_ready && rdy_hi && run_valid && !run_hi)
      |=> (run_hi && run_valid && run_id == $past(rdy_id) && int_valid)); // R3

  AST_SAVED_UNDER_HI: assert property (@(posedge clk) disable iff (!rst_n)
    int_valid |-> (run_valid && run_hi)); // R3

  AST_HI_WAITS_ON_HI: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_empty |-> (run_valid && run_hi)); // R5

  AST_HI_NOT_SLICED: assert property (@(posedge clk) disable iff (!rst_n)
    (run_valid && run_hi && tick && !blk)
      |=> (run_valid && run_hi && run_id == $past(run_id))); // R7

  AST_BLOCK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (blk || tick) |-> !rdy_ready); // R8

  AST_IDLE_MEANS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !run_valid |-> (hi_empty && lo_empty && !int_valid)); // R9
endmodule

bind proc_sched sched_check #(.ID_W(ID_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rdy_valid(rdy_valid),
  .rdy_ready(rdy_ready),
  .rdy_id   (rdy_id),
  .rdy_hi   (rdy_hi),
  .blk      (blk),
  .tick     (tick),
  .run_valid(run_valid),
  .run_id   (run_id),
  .run_hi   (run_hi),
  .hi_empty (hi_empty),
  .lo_empty (lo_empty),
  .int_valid(int_v_q)
);

// File: tb/tb_proc_sched.sv
`timescale 1ns/1ps
module tb_proc_sched;
  localparam int NPROC = 15;
  localparam int ID_W  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rdy_valid = 1'b0, rdy_hi = 1'b0, blk = 1'b0, tick = 1'b0;
  logic [ID_W-1:0] rdy_id = '0;
  logic rdy_ready, run_valid, run_hi;
  logic [ID_W-1:0] run_id;

  always #2 clk = ~clk;

  proc_sched #(.NPROC(NPROC), .ID_W(ID_W)) dut (
    .clk(clk), .rst_n(rst_n), .rdy_valid(rdy_valid), .rdy_ready(rdy_ready),
    .rdy_id(rdy_id), .rdy_hi(rdy_hi), .blk(blk), .tick(tick),
    .run_valid(run_valid), .run_id(run_id), .run_hi(run_hi)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // reference model
  bit m_v, m_hi, m_iv;
  int m_id, m_int;
  int mq_hi[$], mq_lo[$];
  bit busy[NPROC];

  task automatic check(string tag, bit ok, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_run(string tag);
    check(tag, run_valid == m_v, "run_valid", run_valid, m_v);
    if (m_v) begin
      check(tag, run_id == m_id[ID_W-1:0], "run_id", run_id, m_id);
      check(tag, run_hi == m_hi, "run_hi", run_hi, m_hi);
    end
  endtask

  function automatic string model_step(bit b, bit t, bit rv, int id, bit hi);
    string tag;
    tag = "R8";
    if (b) begin
      tag = "R5";
      if (m_v) begin
        busy[m_id] = 0;
        if (mq_hi.size() > 0) begin m_id = mq_hi.pop_front(); m_hi = 1; end
        else if (m_iv) begin m_id = m_int; m_hi = 0; m_iv = 0; end
        else if (mq_lo.size() > 0) begin m_id = mq_lo.pop_front(); m_hi = 0; end
        else begin m_v = 0; tag = "R9"; end
      end
    end else if (t) begin
      if (m_v && !m_hi && mq_lo.size() > 0) begin
        mq_lo.push_back(m_id);
        m_id = mq_lo.pop_front();
        tag = "R6";
      end else tag = "R7";
    end else if (rv) begin
      busy[id] = 1;
      if (!m_v) begin m_v = 1; m_id = id; m_hi = hi; tag = "R2"; end
      else if (hi && !m_hi) begin m_iv = 1; m_int = m_id; m_id = id; m_hi = 1; tag = "R3"; end
      else begin
        if (hi) mq_hi.push_back(id); else mq_lo.push_back(id);
        tag = "R4";
      end
    end
    return tag;
  endfunction

  // called just after a falling edge; returns after the next falling edge
  task automatic step(bit b, bit t, bit rv, int id, bit hi);
    string tag;
    blk = b; tick = t; rdy_valid = rv; rdy_id = id[ID_W-1:0]; rdy_hi = hi;
    #0.5;
    check("R8", rdy_ready == !(b || t), "rdy_ready", rdy_ready, !(b || t));
    tag = model_step(b, t, rv, id, hi);
    @(negedge clk);
    blk = 0; tick = 0; rdy_valid = 0;
    check_run(tag);
  endtask

  function automatic int pick_free(int start);
    for (int k = 0; k < NPROC; k++)
      if (!busy[(start + k) % NPROC]) return (start + k) % NPROC;
    return -1;
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_v = 0; m_hi = 0; m_iv = 0; m_id = 0; m_int = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1", run_valid == 0, "run_valid", run_valid, 0);
    check("R1", rdy_ready == 1, "rdy_ready", rdy_ready, 1);
    // directed corner cases
    step(0, 0, 1, 3, 0);   // R2 idle -> run 3 low
    step(0, 0, 1, 5, 0);   // R4 queue low
    step(0, 0, 1, 7, 0);   // R4
    step(0, 1, 0, 0, 0);   // R6 rotate -> 5
    step(0, 0, 1, 9, 1);   // R3 preempt, 5 saved
    step(0, 0, 1, 10, 1);  // R4 queue high
    step(0, 1, 0, 0, 0);   // R7 tick under high
    step(1, 0, 0, 0, 0);   // R5 -> 10
    step(1, 0, 1, 2, 0);   // R8 block wins, R5 -> saved 5
    step(1, 0, 0, 0, 0);   // R5 -> 7
    step(1, 0, 0, 0, 0);   // R5 -> 3
    step(0, 1, 0, 0, 0);   // R7 low queue empty
    step(1, 0, 0, 0, 0);   // R9 idle
    step(1, 0, 0, 0, 0);   // block while idle is ignored
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      int r, id;
      r = $urandom % 12;
      id = pick_free($urandom % NPROC);
      if (r < 2) step(1, 0, 0, 0, 0);
      else if (r == 2) step(1, 0, id >= 0, (id >= 0) ? id : 0, $urandom % 2);
      else if (r < 5) step(0, 1, 0, 0, 0);
      else if (id >= 0) step(0, 0, 1, id, $urandom % 2);
      else step(1, 0, 0, 0, 0);
    end
    // drain to idle
    for (int i = 0; i < NPROC + 2; i++) step(1, 0, 0, 0, 0);
    check("R9", run_valid == 0, "run_valid after drain", run_valid, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule